// File: doc/BRIEF.md
# Multi-Owner Hardware Lock Array

This block holds a configurable set of hardware locks shared between a group of command channels and the CPU. Each lock is either free, held by one particular channel, or held by the CPU. Channels send decoded lock operations (acquire or release, plus a lock index). A channel whose acquire cannot be granted sees its stall line raised and keeps its request up until the lock becomes free and is granted to it. The CPU makes single-cycle acquire and release attempts. It learns one cycle later whether an acquire was granted or denied, and it is never stalled.

When several requesters compete for one free lock in the same cycle, a fixed priority picks the winner: the lowest channel index wins, and the CPU ranks below every channel. A release from anyone who does not own the lock changes nothing and raises a one-cycle error pulse. Software can read the owner record of any lock through a combinational status port. A constant output reports how many locks the instance has.

Top module: `lock_owner_array`

## Requirements
- R1: After reset every lock is free. The status of every lock reads 0, no stall line is high, and the grant, deny and error outputs are low.
- R2: The status word has 10 bits. Bit 9 means a channel owns the lock, bit 8 means the CPU owns it, and bits 7:0 hold the owning channel index (0 unless a channel owns it). Bits 9 and 8 are never both set. An index with no lock reads 0.
- R3: A channel acquire uses subop code 0. On a free lock it is granted in the same cycle (stall low), and from the next cycle the status shows that channel as owner. An acquire by the current owner is granted and leaves the record unchanged.
- R4: A channel acquire on a lock held by another owner raises that channel's stall in the same cycle. The stall stays high while the lock is held. A release and a competing acquire in the same cycle do not grant the acquire in that cycle. The stall drops in the first cycle the lock is seen free, and ownership passes at the next edge.
- R5: When several acquires target one free lock in the same cycle, the lowest channel index wins and the others stall. A CPU acquire in that cycle is denied.
- R6: A channel release uses subop code 1. Issued by the owning channel, it frees the lock from the next cycle. A CPU release by the CPU owner does the same.
- R7: A release by a channel or by the CPU that does not own the lock leaves the lock unchanged and pulses the error output high for one cycle after the request.
- R8: A CPU acquire on a free lock with no competing channel acquire, or on a lock the CPU already holds, pulses the grant output one cycle later and the lock reads as CPU-owned. Otherwise the deny output pulses and nothing changes. Grant and deny are never high together.
- R9: The lock-count output equals the configured number of locks at all times.
- R10: A lock operation whose index is at or above the lock count changes no lock, never stalls, and pulses the error output. A CPU acquire of this kind is also denied. A channel subop other than 0 or 1 is ignored: no stall, no error, no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chReqValid | input | NUM_CHAN | Per-channel lock operation valid |
| chReqSubop | input | 4*NUM_CHAN | Per-channel subop, 4 bits each (0 acquire, 1 release) |
| chReqIdx | input | IDX_W*NUM_CHAN | Per-channel lock index |
| chStall | output | NUM_CHAN | Acquire pending and not granted this cycle |
| cpuReqValid | input | 1 | CPU lock operation valid (one cycle) |
| cpuReqRelease | input | 1 | 1 = release, 0 = acquire |
| cpuReqIdx | input | IDX_W | CPU lock index |
| cpuGrant | output | 1 | CPU acquire granted (one cycle after request) |
| cpuDeny | output | 1 | CPU acquire refused (one cycle after request) |
| statusIdx | input | IDX_W | Lock selected for status read |
| statusWord | output | 10 | Owner record of the selected lock |
| lockCount | output | IDX_W+1 | Number of locks in this instance |
| relError | output | 1 | One-cycle pulse for a foreign release or a bad index |

## Verification
The bench drives all fifteen non-empty combinations of four channels acquiring one lock together with a CPU acquire. A priority encoder that picks the highest index, or lets the CPU win, would show the wrong owner and the wrong stall pattern. A release and a competing acquire are placed in the same cycle, which catches a design that grants from the freed state one cycle early. Foreign releases by a channel and by the CPU, out-of-range indices and unknown subops are each followed by a status read, so a design that freed the lock or skipped the error pulse is visible at the ports. A full sweep of every channel over every lock checks the owner index field, so a swapped field or a stuck id bit appears as a wrong status value.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int SUBOP_W  = 4;
  localparam int OWNER_W  = 8;
  localparam int STATUS_W = OWNER_W + 2;

  typedef enum logic [SUBOP_W-1:0] {
    SUB_ACQ = 4'd0,
    SUB_REL = 4'd1
  } subop_e;

  // per-lock update strobes from control to storage
  typedef struct packed {
    logic               setChan;
    logic               setCpu;
    logic               clr;
    logic [OWNER_W-1:0] newId;
  } lockStrobe_t;

  // block-level event strobes, registered by storage
  typedef struct packed {
    logic cpuGrant;
    logic cpuDeny;
    logic err;
  } evtStrobe_t;
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int NUM_CHAN  = 4,
  parameter int NUM_LOCKS = 8,
  parameter int IDX_W     = 8
) (
  input  logic [NUM_CHAN-1:0]          chReqValid,
  input  logic [NUM_CHAN*SUBOP_W-1:0]  chReqSubop,
  input  logic [NUM_CHAN*IDX_W-1:0]    chReqIdx,
  input  logic                         cpuReqValid,
  input  logic                         cpuReqRelease,
  input  logic [IDX_W-1:0]             cpuReqIdx,
  input  logic [NUM_LOCKS-1:0]         chOwn,
  input  logic [NUM_LOCKS-1:0]         cpuOwn,
  input  logic [NUM_LOCKS*OWNER_W-1:0] ownerId,
  output lockStrobe_t [NUM_LOCKS-1:0]  lockStb,
  output evtStrobe_t                   evtStb,
  output logic [NUM_CHAN-1:0]          chStall
);
  localparam logic [IDX_W:0] LOCK_LIMIT = (IDX_W+1)'(NUM_LOCKS);

  logic [IDX_W-1:0]    chIdx [NUM_CHAN];
  logic [NUM_CHAN-1:0] chAcq, chRel, chRange, grantCh;
  logic                cpuRange;
  logic                isFree, taken;
  logic [OWNER_W-1:0]  curId;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_dec
    assign chIdx[c]   = chReqIdx[c*IDX_W +: IDX_W];
    assign chRange[c] = {1'b0, chIdx[c]} < LOCK_LIMIT;
    assign chAcq[c]   = chReqValid[c] && (chReqSubop[c*SUBOP_W +: SUBOP_W] == SUB_ACQ);
    assign chRel[c]   = chReqValid[c] && (chReqSubop[c*SUBOP_W +: SUBOP_W] == SUB_REL);
    assign chStall[c] = chAcq[c] && chRange[c] && !grantCh[c];
  end

  assign cpuRange = {1'b0, cpuReqIdx} < LOCK_LIMIT;

  always_comb begin
    lockStb = '0;
    evtStb  = '0;
    grantCh = '0;
    isFree  = 1'b0;
    taken   = 1'b0;
    curId   = '0;
    // out-of-range operations never touch a lock
    for (int c = 0; c < NUM_CHAN; c++) begin
      if ((chAcq[c] || chRel[c]) && !chRange[c]) evtStb.err = 1'b1;
    end
    if (cpuReqValid && !cpuRange) begin
      evtStb.err = 1'b1;
      if (!cpuReqRelease) evtStb.cpuDeny = 1'b1;
    end
    for (int l = 0; l < NUM_LOCKS; l++) begin
      isFree = !chOwn[l] && !cpuOwn[l];
      taken  = 1'b0;
      curId  = ownerId[l*OWNER_W +: OWNER_W];
      // channels scanned from index 0: first hit on a free lock wins
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (chAcq[c] && chRange[c] && chIdx[c] == IDX_W'(l)) begin
          if (isFree && !taken) begin
            taken              = 1'b1;
            lockStb[l].setChan = 1'b1;
            lockStb[l].newId   = OWNER_W'(c);
            grantCh[c]         = 1'b1;
          end else if (chOwn[l] && curId == OWNER_W'(c)) begin
            grantCh[c] = 1'b1;
          end
        end
        if (chRel[c] && chRange[c] && chIdx[c] == IDX_W'(l)) begin
          if (chOwn[l] && curId == OWNER_W'(c)) lockStb[l].clr = 1'b1;
          else                                  evtStb.err     = 1'b1;
        end
      end
      // CPU ranks below every channel
      if (cpuReqValid && cpuRange && cpuReqIdx == IDX_W'(l)) begin
        if (!cpuReqRelease) begin
          if (isFree && !taken) begin
            lockStb[l].setCpu = 1'b1;
            evtStb.cpuGrant   = 1'b1;
          end else if (cpuOwn[l]) begin
            evtStb.cpuGrant = 1'b1;
          end else begin
            evtStb.cpuDeny = 1'b1;
          end
        end else begin
          if (cpuOwn[l]) lockStb[l].clr = 1'b1;
          else           evtStb.err     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lock_store.sv
module lock_store
  import lock_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int IDX_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  lockStrobe_t [NUM_LOCKS-1:0]  lockStb,
  input  evtStrobe_t                   evtStb,
  input  logic [IDX_W-1:0]             statusIdx,
  output logic [NUM_LOCKS-1:0]         chOwn,
  output logic [NUM_LOCKS-1:0]         cpuOwn,
  output logic [NUM_LOCKS*OWNER_W-1:0] ownerId,
  output logic [STATUS_W-1:0]          statusWord,
  output logic                         cpuGrant,
  output logic                         cpuDeny,
  output logic                         relError
);
  logic [OWNER_W-1:0] idQ [NUM_LOCKS];

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chOwn[l]  <= 1'b0;
        cpuOwn[l] <= 1'b0;
        idQ[l]    <= '0;
      end else if (lockStb[l].clr) begin
        chOwn[l]  <= 1'b0;
        cpuOwn[l] <= 1'b0;
        idQ[l]    <= '0;
      end else if (lockStb[l].setChan) begin
        chOwn[l] <= 1'b1;
        idQ[l]   <= lockStb[l].newId;
      end else if (lockStb[l].setCpu) begin
        cpuOwn[l] <= 1'b1;
      end
    end
    assign ownerId[l*OWNER_W +: OWNER_W] = idQ[l];

    p_clr_needs_owner_r6: assert property (@(posedge clk) disable iff (!rstN)
      lockStb[l].clr |-> (chOwn[l] || cpuOwn[l]));
    p_set_needs_free_r3: assert property (@(posedge clk) disable iff (!rstN)
      (lockStb[l].setChan || lockStb[l].setCpu) |-> !(chOwn[l] || cpuOwn[l]));
    p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (chOwn[l] && !lockStb[l].clr) |=> (chOwn[l] && $stable(idQ[l])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuGrant <= 1'b0;
      cpuDeny  <= 1'b0;
      relError <= 1'b0;
    end else begin
      cpuGrant <= evtStb.cpuGrant;
      cpuDeny  <= evtStb.cpuDeny;
      relError <= evtStb.err;
    end
  end

  always_comb begin
    statusWord = '0;
    for (int l = 0; l < NUM_LOCKS; l++) begin
      if (statusIdx == IDX_W'(l)) statusWord = {chOwn[l], cpuOwn[l], idQ[l]};
    end
  end

  p_status_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[STATUS_W-1] && statusWord[STATUS_W-2]));
  p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuGrant && cpuDeny));
endmodule

// File: rtl/lock_owner_array.sv
module lock_owner_array
  import lock_pkg::*;
#(
  parameter int NUM_CHAN  = 4,
  parameter int NUM_LOCKS = 8,
  parameter int IDX_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CHAN-1:0]         chReqValid,
  input  logic [NUM_CHAN*4-1:0]       chReqSubop,
  input  logic [NUM_CHAN*IDX_W-1:0]   chReqIdx,
  output logic [NUM_CHAN-1:0]         chStall,
  input  logic                        cpuReqValid,
  input  logic                        cpuReqRelease,
  input  logic [IDX_W-1:0]            cpuReqIdx,
  output logic                        cpuGrant,
  output logic                        cpuDeny,
  input  logic [IDX_W-1:0]            statusIdx,
  output logic [9:0]                  statusWord,
  output logic [IDX_W:0]              lockCount,
  output logic                        relError
);
  lockStrobe_t [NUM_LOCKS-1:0]  lockStb;
  evtStrobe_t                   evtStb;
  logic [NUM_LOCKS-1:0]         chOwn, cpuOwn;
  logic [NUM_LOCKS*OWNER_W-1:0] ownerId;

  assign lockCount = (IDX_W+1)'(NUM_LOCKS);

  lock_ctrl #(.NUM_CHAN(NUM_CHAN), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_ctrl (
    .chReqValid(chReqValid), .chReqSubop(chReqSubop), .chReqIdx(chReqIdx),
    .cpuReqValid(cpuReqValid), .cpuReqRelease(cpuReqRelease), .cpuReqIdx(cpuReqIdx),
    .chOwn(chOwn), .cpuOwn(cpuOwn), .ownerId(ownerId),
    .lockStb(lockStb), .evtStb(evtStb), .chStall(chStall)
  );

  lock_store #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .lockStb(lockStb), .evtStb(evtStb),
    .statusIdx(statusIdx), .chOwn(chOwn), .cpuOwn(cpuOwn), .ownerId(ownerId),
    .statusWord(statusWord), .cpuGrant(cpuGrant), .cpuDeny(cpuDeny),
    .relError(relError)
  );
endmodule

// File: tb/lock_owner_array_bench.sv
`timescale 1ns/1ps
module lock_owner_array_bench;
  localparam int NCH = 4;
  localparam int NL  = 8;
  localparam int IW  = 8;
  localparam logic [3:0] ACQ = 4'd0;
  localparam logic [3:0] REL = 4'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0]    chReqValid = '0;
  logic [NCH*4-1:0]  chReqSubop = '0;
  logic [NCH*IW-1:0] chReqIdx = '0;
  logic [NCH-1:0]    chStall;
  logic cpuReqValid = 1'b0, cpuReqRelease = 1'b0;
  logic [IW-1:0] cpuReqIdx = '0;
  logic cpuGrant, cpuDeny, relError;
  logic [IW-1:0] statusIdx = '0;
  logic [9:0] statusWord;
  logic [IW:0] lockCount;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lock_owner_array #(.NUM_CHAN(NCH), .NUM_LOCKS(NL), .IDX_W(IW)) u_lock_owner_array (
    .clk(clk), .rstN(rstN), .chReqValid(chReqValid), .chReqSubop(chReqSubop),
    .chReqIdx(chReqIdx), .chStall(chStall), .cpuReqValid(cpuReqValid),
    .cpuReqRelease(cpuReqRelease), .cpuReqIdx(cpuReqIdx), .cpuGrant(cpuGrant),
    .cpuDeny(cpuDeny), .statusIdx(statusIdx), .statusWord(statusWord),
    .lockCount(lockCount), .relError(relError)
  );

  function automatic logic [9:0] stCh(int c);
    return {2'b10, 8'(c)};
  endfunction
  localparam logic [9:0] ST_CPU = 10'h100;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #0.2;
  endtask

  task automatic clearAll();
    chReqValid = '0;
    cpuReqValid = 1'b0;
  endtask

  task automatic chReq(input int c, input logic [3:0] sub, input logic [7:0] idx);
    chReqValid[c] = 1'b1;
    chReqSubop[c*4 +: 4] = sub;
    chReqIdx[c*IW +: IW] = idx;
  endtask

  task automatic cpuReq(input logic rel, input logic [7:0] idx);
    cpuReqValid = 1'b1;
    cpuReqRelease = rel;
    cpuReqIdx = idx;
  endtask

  task automatic readSt(input int idx, output logic [9:0] st);
    statusIdx = IW'(idx);
    #0.1;
    st = statusWord;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] st;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();

    // R1 / R9: reset state
    for (int l = 0; l < NL; l++) begin
      readSt(l, st);
      chk("R1 status after reset", st, 0);
    end
    chk("R1 stall after reset", chStall, 0);
    chk("R1 flags after reset", {cpuGrant, cpuDeny, relError}, 0);
    chk("R9 lock count", lockCount, NL);
    readSt(9, st);
    chk("R2 status of missing lock", st, 0);

    // R3 / R6 / R2: every channel over every lock
    for (int c = 0; c < NCH; c++) begin
      for (int l = 0; l < NL; l++) begin
        chReq(c, ACQ, 8'(l));
        settle();
        chk("R3 no stall on free lock", chStall, 0);
        step();
        clearAll();
        readSt(l, st);
        chk("R2 R3 channel owner record", st, stCh(c));
        chReq(c, REL, 8'(l));
        step();
        clearAll();
        readSt(l, st);
        chk("R6 release by owner frees", st, 0);
        chk("R6 no error on owner release", relError, 0);
      end
    end

    // R4: contention and hand-over
    chReq(1, ACQ, 8'd3);
    step();
    clearAll();
    chReq(2, ACQ, 8'd3);
    settle();
    chk("R4 stall on held lock", chStall, 4'b0100);
    step();
    settle();
    chk("R4 stall persists", chStall, 4'b0100);
    readSt(3, st);
    chk("R4 owner unchanged while waiting", st, stCh(1));
    chReq(1, REL, 8'd3);
    settle();
    chk("R4 no grant in release cycle", chStall, 4'b0100);
    step();
    chReqValid[1] = 1'b0;
    settle();
    chk("R4 stall drops once free", chStall, 0);
    readSt(3, st);
    chk("R4 lock free before hand-over", st, 0);
    step();
    clearAll();
    readSt(3, st);
    chk("R4 waiting channel owns lock", st, stCh(2));
    chReq(2, REL, 8'd3);
    step();
    clearAll();

    // R5: all request masks with a competing CPU acquire
    for (int m = 1; m < 16; m++) begin
      int w;
      w = -1;
      for (int c = NCH - 1; c >= 0; c--) if (m[c]) w = c;
      for (int c = 0; c < NCH; c++) if (m[c]) chReq(c, ACQ, 8'd5);
      cpuReq(1'b0, 8'd5);
      settle();
      chk("R5 stall pattern", chStall, 4'(m) & ~(4'b1 << w));
      step();
      clearAll();
      chk("R5 CPU denied against channels", {cpuGrant, cpuDeny}, 2'b01);
      readSt(5, st);
      chk("R5 lowest channel wins", st, stCh(w));
      chReq(w, REL, 8'd5);
      step();
      clearAll();
      readSt(5, st);
      chk("R5 released after round", st, 0);
    end

    // R8 / R7: CPU ownership
    cpuReq(1'b0, 8'd2);
    step();
    clearAll();
    chk("R8 CPU grant", {cpuGrant, cpuDeny}, 2'b10);
    readSt(2, st);
    chk("R8 CPU owner record", st, ST_CPU);
    chReq(0, ACQ, 8'd2);
    settle();
    chk("R4 channel stalls on CPU lock", chStall, 4'b0001);
    step();
    clearAll();
    cpuReq(1'b0, 8'd2);
    step();
    clearAll();
    chk("R8 CPU re-acquire granted", {cpuGrant, cpuDeny}, 2'b10);
    readSt(2, st);
    chk("R8 record kept on re-acquire", st, ST_CPU);
    chReq(3, REL, 8'd2);
    step();
    clearAll();
    chk("R7 foreign channel release error", relError, 1);
    readSt(2, st);
    chk("R7 lock kept after foreign release", st, ST_CPU);
    step();
    chk("R7 error is a pulse", relError, 0);
    cpuReq(1'b1, 8'd2);
    step();
    clearAll();
    readSt(2, st);
    chk("R6 CPU release frees", st, 0);
    chk("R6 no error on CPU release", relError, 0);

    // R7: CPU release of free and of channel-held locks
    cpuReq(1'b1, 8'd4);
    step();
    clearAll();
    chk("R7 CPU release of free lock error", relError, 1);
    readSt(4, st);
    chk("R7 free lock stays free", st, 0);
    chReq(0, ACQ, 8'd6);
    step();
    clearAll();
    chReq(1, REL, 8'd6);
    step();
    clearAll();
    chk("R7 other channel release error", relError, 1);
    readSt(6, st);
    chk("R7 owner kept", st, stCh(0));
    cpuReq(1'b1, 8'd6);
    step();
    clearAll();
    chk("R7 CPU release of channel lock error", relError, 1);
    readSt(6, st);
    chk("R7 owner kept after CPU release", st, stCh(0));
    chReq(0, REL, 8'd6);
    step();
    clearAll();
    readSt(6, st);
    chk("R6 owner release after errors", st, 0);

    // R10: bad index and unknown subop
    chReq(1, ACQ, 8'd8);
    settle();
    chk("R10 no stall on bad index", chStall, 0);
    step();
    clearAll();
    chk("R10 bad index error", relError, 1);
    for (int l = 0; l < NL; l++) begin
      readSt(l, st);
      chk("R10 no lock touched", st, 0);
    end
    chReq(2, 4'd5, 8'd1);
    settle();
    chk("R10 no stall on unknown subop", chStall, 0);
    step();
    clearAll();
    chk("R10 unknown subop no error", relError, 0);
    readSt(1, st);
    chk("R10 unknown subop no change", st, 0);
    cpuReq(1'b0, 8'd200);
    step();
    clearAll();
    chk("R10 CPU bad index denied", {cpuGrant, cpuDeny, relError}, 3'b011);

    // R3: re-acquire by owner
    chReq(2, ACQ, 8'd0);
    step();
    clearAll();
    chReq(2, ACQ, 8'd0);
    settle();
    chk("R3 owner re-acquire no stall", chStall, 0);
    step();
    clearAll();
    readSt(0, st);
    chk("R3 owner re-acquire keeps record", st, stCh(2));
    chk("R3 re-acquire no error", relError, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule